// File: doc/BRIEF.md
# External Memory Mode Register and Chip-Select Gate

This block sits in front of an external memory controller. It keeps three control bits (controller enable, boot address mirror and low-power mode) and decides for each incoming memory access whether the access may proceed. If it may, the block raises one of two chip selects. If it may not, the block answers with an error. The refresh logic downstream takes a refresh-enable signal from this block, which tells it whether refresh must keep running.

A request to disable the controller or to enter low-power mode does not apply at once. It is held until the timing engines report idle. A request to re-enable or to leave low-power mode applies on the next clock. The mirror bit sends accesses aimed at the lower chip-select region to chip select 1, so a boot device wired to that select is reached at reset. The block has two synchronous resets. Power-on reset restores every bit. Warm reset restores enable and low-power and leaves the mirror setting as it was.

Top module: `memctl_gate`

## Requirements
- R1: After power-on reset the readback word `reg_rdata` equals 0x00000003: bit 0 is enable (1), bit 1 is mirror (1), bit 2 is low-power (0), and bits 31:3 read zero.
- R2: Warm reset sets enable to 1 and low-power to 0, discards any held mode request, and leaves the mirror bit unchanged. Power-on reset takes priority over warm reset.
- R3: A write places `reg_wdata[1]` into the mirror bit on the next clock with no idle condition. The register can be written and read back while the controller is disabled or in low-power mode.
- R4: Writing 0 to bit 0 clears enable only on the clock edge after one where `ctl_idle` is 1. Until then enable reads 1, and the request stays held.
- R5: Writing 1 to bit 2 sets low-power only on the clock edge after one where `ctl_idle` is 1. Until then low-power reads 0, and the request stays held.
- R6: Writing 1 to bit 0, or 0 to bit 2, applies on the next clock regardless of `ctl_idle`. It also cancels any held request for that bit.
- R7: While access is allowed, a valid access with an address below `CS1_BASE` asserts `cs_o[0]` and an address at or above `CS1_BASE` asserts `cs_o[1]`. Both happen in the same cycle, with `acc_ready` high. At most one select is high, and only while `acc_valid` is high.
- R8: While mirror is 1, an allowed access below `CS1_BASE` asserts `cs_o[1]` instead of `cs_o[0]`.
- R9: A valid access while disabled or in low-power mode asserts no chip select. The cycle after the request, `acc_error` is 1 and `acc_ready` is 0. The following cycle both are 1.
- R10: `refresh_en` equals the enable bit. It stays 1 in low-power mode and while a disable request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 3 | Write data: bit 0 enable, bit 1 mirror, bit 2 low-power |
| reg_rdata | output | 32 | Control register readback |
| ctl_idle | input | 1 | Timing engines report idle |
| acc_valid | input | 1 | Memory access request, held until acc_ready |
| acc_addr | input | ADDR_W | Access address |
| acc_ready | output | 1 | Access accepted or error response done |
| acc_error | output | 1 | Error response |
| cs_o | output | 2 | Chip selects, bit n for select n |
| refresh_en | output | 1 | Refresh must keep running |

## Verification
A wrong internal state shows at the ports quickly. A held request that applies without idle, or never applies, flips the readback bit and `refresh_en` one cycle away from the edge after idle. A stuck mirror bit shows up as the wrong chip select on the very next allowed access. If the gate decides wrongly, a select can rise on a forbidden access in the same cycle, or the error response can come out with the wrong length. So each scenario checks the select level during the request cycle and both error cycles, and it checks the readback around every idle edge.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    localparam int CTL_W  = 3;
    localparam int RDATA_W = 32;

    typedef struct packed {
        logic lowpwr;
        logic mirror;
        logic enable;
    } ctl_t;

    typedef enum logic [1:0] {
        ERS_IDLE = 2'd0,
        ERS_WAIT = 2'd1,
        ERS_DONE = 2'd2
    } err_state_e;

    localparam ctl_t CTL_POR = '{lowpwr: 1'b0, mirror: 1'b1, enable: 1'b1};

    // Select pattern for a region flag, with the boot mirror applied.
    function automatic logic [1:0] cs_pattern(input logic upper, input logic mirror);
        if (upper || mirror) return 2'b10;
        return 2'b01;
    endfunction

endpackage

// File: rtl/memctl_ctrl_reg.sv
module memctl_ctrl_reg
    import memctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             idle,
    output ctl_t             ctl
);

    ctl_t ctl_q;
    logic hold_dis_q;
    logic hold_lp_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctl_q      <= CTL_POR;
            hold_dis_q <= 1'b0;
            hold_lp_q  <= 1'b0;
        end else if (warm_rst) begin
            ctl_q.enable <= 1'b1;
            ctl_q.lowpwr <= 1'b0;
            hold_dis_q   <= 1'b0;
            hold_lp_q    <= 1'b0;
        end else if (wr) begin
            ctl_q.mirror <= wdata[1];
            if (wdata[0]) begin
                ctl_q.enable <= 1'b1;
                hold_dis_q   <= 1'b0;
            end else if (idle) begin
                ctl_q.enable <= 1'b0;
                hold_dis_q   <= 1'b0;
            end else begin
                hold_dis_q   <= 1'b1;
            end
            if (!wdata[2]) begin
                ctl_q.lowpwr <= 1'b0;
                hold_lp_q    <= 1'b0;
            end else if (idle) begin
                ctl_q.lowpwr <= 1'b1;
                hold_lp_q    <= 1'b0;
            end else begin
                hold_lp_q    <= 1'b1;
            end
        end else if (idle) begin
            if (hold_dis_q) begin
                ctl_q.enable <= 1'b0;
                hold_dis_q   <= 1'b0;
            end
            if (hold_lp_q) begin
                ctl_q.lowpwr <= 1'b1;
                hold_lp_q    <= 1'b0;
            end
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/memctl_cs_decode.sv
module memctl_cs_decode
    import memctl_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CS1_BASE = 16'h8000
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mirror,
    input  logic              grant_ok,
    output logic [1:0]        cs
);

    logic upper;

    always_comb begin
        upper = (addr >= CS1_BASE);
        cs    = (valid && grant_ok) ? cs_pattern(upper, mirror) : 2'b00;
    end

endmodule

// File: rtl/memctl_err_resp.sv
module memctl_err_resp
    import memctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reject,
    output logic busy,
    output logic err,
    output logic done
);

    err_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ERS_IDLE;
        end else begin
            unique case (st_q)
                ERS_IDLE: if (reject) st_q <= ERS_WAIT;
                ERS_WAIT: st_q <= ERS_DONE;
                ERS_DONE: st_q <= ERS_IDLE;
                default:  st_q <= ERS_IDLE;
            endcase
        end
    end

    assign busy = (st_q != ERS_IDLE);
    assign err  = busy;
    assign done = (st_q == ERS_DONE);

endmodule

// File: rtl/memctl_gate.sv
module memctl_gate
    import memctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CS1_BASE = 16'h8000
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                warm_rst,
    input  logic                reg_wr,
    input  logic [CTL_W-1:0]    reg_wdata,
    output logic [RDATA_W-1:0]  reg_rdata,
    input  logic                ctl_idle,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                acc_ready,
    output logic                acc_error,
    output logic [1:0]          cs_o,
    output logic                refresh_en
);

    ctl_t ctl;
    logic allowed;
    logic err_busy;
    logic err_done;
    logic grant_ok;
    logic reject;

    memctl_ctrl_reg u_reg (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .idle     (ctl_idle),
        .ctl      (ctl)
    );

    assign allowed  = ctl.enable && !ctl.lowpwr;
    assign grant_ok = allowed && !err_busy;
    assign reject   = acc_valid && !allowed && !err_busy;

    memctl_cs_decode #(
        .ADDR_W   (ADDR_W),
        .CS1_BASE (CS1_BASE)
    ) u_dec (
        .valid    (acc_valid),
        .addr     (acc_addr),
        .mirror   (ctl.mirror),
        .grant_ok (grant_ok),
        .cs       (cs_o)
    );

    memctl_err_resp u_err (
        .clk    (clk),
        .rst    (por_rst || warm_rst),
        .reject (reject),
        .busy   (err_busy),
        .err    (acc_error),
        .done   (err_done)
    );

    assign acc_ready  = (|cs_o) || err_done;
    assign refresh_en = ctl.enable;
    assign reg_rdata  = {{(RDATA_W-CTL_W){1'b0}}, ctl};

endmodule

// File: rtl/memctl_gate_chk.sv
module memctl_gate_chk (
    input logic        clk,
    input logic        por_rst,
    input logic        warm_rst,
    input logic [31:0] reg_rdata,
    input logic        ctl_idle,
    input logic        acc_valid,
    input logic        acc_ready,
    input logic        acc_error,
    input logic [1:0]  cs_o,
    input logic        refresh_en
);

    a_r7_one_select: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        $onehot0(cs_o));

    a_r7_select_needs_valid: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        (|cs_o) |-> acc_valid);

    a_r9_no_select_on_error: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        acc_error |-> (cs_o == 2'b00));

    a_r9_error_two_cycles: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        (acc_error && !acc_ready) |=> (acc_error && acc_ready));

    a_r4_disable_after_idle: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        $fell(reg_rdata[0]) |-> $past(ctl_idle));

    a_r5_lowpower_after_idle: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        $rose(reg_rdata[2]) |-> $past(ctl_idle));

    a_r10_refresh_tracks_enable: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        refresh_en == reg_rdata[0]);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        reg_rdata[31:3] == '0);

endmodule

bind memctl_gate memctl_gate_chk u_chk (
    .clk        (clk),
    .por_rst    (por_rst),
    .warm_rst   (warm_rst),
    .reg_rdata  (reg_rdata),
    .ctl_idle   (ctl_idle),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_error  (acc_error),
    .cs_o       (cs_o),
    .refresh_en (refresh_en)
);

// File: tb/memctl_gate_tb_top.sv
module memctl_gate_tb_top;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              por_rst;
    logic              warm_rst;
    logic              reg_wr;
    logic [2:0]        reg_wdata;
    logic [31:0]       reg_rdata;
    logic              ctl_idle;
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_ready;
    logic              acc_error;
    logic [1:0]        cs_o;
    logic              refresh_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    memctl_gate #(.ADDR_W(ADDR_W), .CS1_BASE(16'h8000)) dut_i (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_idle(ctl_idle), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_ready(acc_ready), .acc_error(acc_error), .cs_o(cs_o),
        .refresh_en(refresh_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [2:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic set_idle_one_cycle();
        @(negedge clk);
        ctl_idle = 1'b1;
        @(negedge clk);
        ctl_idle = 1'b0;
        #1;
    endtask

    task automatic access(input string req, input logic [15:0] a, input logic [1:0] exp_cs, input bit exp_err);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        #1;
        check(req, {30'd0, cs_o}, {30'd0, exp_cs});
        if (exp_err) begin
            check(req, {31'd0, acc_ready}, 32'd0);
            @(negedge clk); #1;
            check(req, {29'd0, acc_error, acc_ready, |cs_o}, {29'd0, 3'b100});
            @(negedge clk); #1;
            check(req, {29'd0, acc_error, acc_ready, |cs_o}, {29'd0, 3'b110});
        end else begin
            check(req, {30'd0, acc_error, acc_ready}, {30'd0, 2'b01});
        end
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
    endtask

    task automatic do_por();
        @(negedge clk);
        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        do_por();
        check("R1 readback after power-on", reg_rdata, 32'h3);
        check("R10 refresh after power-on", {31'd0, refresh_en}, 32'd1);
        check("R1 no select at rest", {30'd0, cs_o}, 32'd0);
    endtask

    task automatic t_decode();
        access("R8 mirrored low region", 16'h0010, 2'b10, 1'b0);
        access("R8 mirrored high region", 16'h9000, 2'b10, 1'b0);
        write_ctl(3'b001);
        check("R3 mirror cleared", reg_rdata, 32'h1);
        access("R7 low region", 16'h7FFF, 2'b01, 1'b0);
        access("R7 boundary region", 16'h8000, 2'b10, 1'b0);
    endtask

    task automatic t_disable_wait();
        write_ctl(3'b000);
        check("R4 disable held without idle", reg_rdata, 32'h1);
        tick(3);
        check("R4 disable still held", reg_rdata, 32'h1);
        check("R10 refresh while disable held", {31'd0, refresh_en}, 32'd1);
        set_idle_one_cycle();
        check("R4 disable applied after idle", reg_rdata, 32'h0);
        check("R10 refresh off while disabled", {31'd0, refresh_en}, 32'd0);
        access("R9 access while disabled", 16'h0100, 2'b00, 1'b1);
        write_ctl(3'b010);
        check("R3 mirror writable while disabled", reg_rdata, 32'h2);
        write_ctl(3'b001);
        check("R6 enable applies without idle", reg_rdata, 32'h1);
        access("R7 access after re-enable", 16'h0100, 2'b01, 1'b0);
    endtask

    task automatic t_lowpower();
        write_ctl(3'b101);
        check("R5 low-power held without idle", reg_rdata, 32'h1);
        access("R5 access allowed while low-power held", 16'hA000, 2'b10, 1'b0);
        set_idle_one_cycle();
        check("R5 low-power applied after idle", reg_rdata, 32'h5);
        check("R10 refresh kept in low-power", {31'd0, refresh_en}, 32'd1);
        access("R9 access in low-power", 16'hA000, 2'b00, 1'b1);
        write_ctl(3'b001);
        check("R6 low-power exit without idle", reg_rdata, 32'h1);
    endtask

    task automatic t_cancel();
        write_ctl(3'b000);
        write_ctl(3'b001);
        set_idle_one_cycle();
        check("R6 held disable cancelled", reg_rdata, 32'h1);
        write_ctl(3'b100);
        write_ctl(3'b000);
        set_idle_one_cycle();
        check("R6 held low-power cancelled", reg_rdata, 32'h0);
        write_ctl(3'b001);
    endtask

    task automatic t_idle_same_cycle();
        @(negedge clk);
        ctl_idle = 1'b1; reg_wr = 1'b1; reg_wdata = 3'b100;
        @(negedge clk);
        ctl_idle = 1'b0; reg_wr = 1'b0;
        #1;
        check("R5 low-power with idle in write cycle", reg_rdata, 32'h4);
        write_ctl(3'b001);
    endtask

    task automatic t_warm();
        write_ctl(3'b101);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        #1;
        check("R2 warm reset keeps mirror clear", reg_rdata, 32'h1);
        set_idle_one_cycle();
        check("R2 warm reset dropped held request", reg_rdata, 32'h1);
        write_ctl(3'b010);
        set_idle_one_cycle();
        check("R2 disabled before warm reset", reg_rdata, 32'h2);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        #1;
        check("R2 warm reset re-enables, mirror kept", reg_rdata, 32'h3);
        write_ctl(3'b000);
        set_idle_one_cycle();
        do_por();
        check("R1 power-on restores all bits", reg_rdata, 32'h3);
    endtask

    initial begin
        por_rst = 1'b1; warm_rst = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        ctl_idle = 1'b0; acc_valid = 1'b0; acc_addr = '0;
        tick(2);
        t_reset_state();
        t_decode();
        t_disable_wait();
        t_lowpower();
        t_cancel();
        t_idle_same_cycle();
        t_warm();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule